// File: doc/BRIEF.md
# YUV Chroma-Subsampling Word Packer

The packer takes one pixel per transfer: an 8-bit luma sample, two 8-bit colour-difference samples, and markers that flag the first and last pixel of a line. It decimates the chroma and packs the surviving bytes into 32-bit words for a memory writer. Two layouts are available. The 4:2:2 layout keeps one chroma pair for every two luma samples. The 4:1:1 layout keeps one chroma pair for every four luma samples and places eight pixels in three words. In both layouts the chroma pair that is kept is the one sampled with the first luma sample of its group. Chroma from the other pixels of the group is dropped and never averaged.

Every sample is limited to its nominal coding range before it is packed. In the 4:2:2 layout a line can begin at any byte lane of its first word, so that the destination address need not be word aligned. If a line stops partway through a group, the missing luma bytes are filled with black. The last word of the line is then sent with byte enables that mark only the filled lanes, and a word-end-of-line flag. Both the pixel input and the word output use valid/ready handshakes.

Top module: `yuvp_packer`

## Requirements
- R1: With `cfg_mode`=0 (4:2:2), each group of two pixels produces four bytes. From bit 7:0 upward, the byte order is U, Y of pixel 0, V, Y of pixel 1. When `line_ofs`=0, the first byte of a line is in lane 0 (bits 7:0).
- R2: In 4:2:2, U and V come from the first pixel of the pair. The U and V presented with the second pixel have no effect on the output.
- R3: With `cfg_mode`=1 (4:1:1), each group of four pixels produces six bytes, in the order U, Y0, Y1, V, Y2, Y3. Eight pixels therefore fill exactly three words, all four lanes of each enabled.
- R4: In 4:1:1, U and V come from the first pixel of each group of four. The chroma presented with the other three pixels has no effect.
- R5: Before packing, every luma byte is limited to the range 16 to 235.
- R6: Before packing, every U and V byte is limited to the range 16 to 240.
- R7: In 4:2:2, the first byte of a line goes to the lane given by `line_ofs`, which is sampled with the pixel that carries `in_sol`. The lanes below it are disabled in `out_be`, and the following bytes continue in order.
- R8: In 4:1:1, `line_ofs` is ignored, and every line starts in lane 0.
- R9: A line whose pixel count is not a whole number of groups is padded to the end of its group with luma 16. The group's chroma is taken from the group's first pixel. The final word of the line has `out_eol`=1, and `out_be` covers only the lanes that hold bytes. The next line starts in a new word.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_be` and `out_eol` stay unchanged. No byte is lost or repeated, whatever pattern `out_ready` follows.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Layout select: 0 for 4:2:2, 1 for 4:1:1 |
| line_ofs | input | 2 | Start lane of a line in 4:2:2 (low address bits) |
| in_valid | input | 1 | A pixel is offered |
| in_ready | output | 1 | The packer can accept a pixel |
| in_sol | input | 1 | The pixel is the first of its line |
| in_eol | input | 1 | The pixel is the last of its line |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | U colour-difference sample |
| in_v | input | 8 | V colour-difference sample |
| out_valid | output | 1 | A packed word is offered |
| out_ready | input | 1 | The downstream side takes the word |
| out_data | output | 32 | Packed word, lane 0 in bits 7:0 |
| out_be | output | 4 | Per-lane byte enables |
| out_eol | output | 1 | The word is the last one of its line |

## Verification
The assertions assume that lines are well formed: `in_sol` comes only on the first pixel after an `in_eol`, and `cfg_mode` changes only between lines. Under these assumptions, every word that is not the last of its line ends in an enabled lane 3, and every enabled byte lies between 16 and 240. The stimulus drives each line from first to last pixel, with sol and eol set, and holds `cfg_mode` and `line_ofs` constant for the whole line. It changes them only after the expected words of the line have all been observed.

// File: rtl/yuvp_pkg.sv
package yuvp_pkg;

  localparam int LANES    = 4;
  localparam int PUSH_MAX = 8;   // 3 offset dummies + 4 bytes, or 6 bytes
  localparam logic [7:0] Y_LO = 8'd16;
  localparam logic [7:0] Y_HI = 8'd235;
  localparam logic [7:0] C_LO = 8'd16;
  localparam logic [7:0] C_HI = 8'd240;
  localparam logic [7:0] Y_PAD = 8'd16;

  typedef enum logic {MODE_422 = 1'b0, MODE_411 = 1'b1} yuvp_mode_e;
  typedef enum logic [1:0] {SK_U, SK_V, SK_Y} slot_kind_e;

  typedef struct packed {
    logic       en;
    logic       last;
    logic [7:0] b;
  } yuvp_ent_t;

  function automatic logic [7:0] clamp8(logic [7:0] x, logic [7:0] lo, logic [7:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // pixels per chroma group
  function automatic logic [2:0] grp_pix(yuvp_mode_e m);
    return (m == MODE_422) ? 3'd2 : 3'd4;
  endfunction

  // first byte slot owned by pixel p inside its group; p == grp_pix gives group size
  function automatic logic [2:0] pix_first(yuvp_mode_e m, logic [2:0] p);
    if (m == MODE_422) begin
      case (p)
        3'd0:    return 3'd0;
        3'd1:    return 3'd2;
        default: return 3'd4;
      endcase
    end
    case (p)
      3'd0:    return 3'd0;
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  function automatic slot_kind_e slot_kind(yuvp_mode_e m, logic [2:0] s);
    if (s == 3'd0) return SK_U;
    if ((m == MODE_422 && s == 3'd2) || (m == MODE_411 && s == 3'd3)) return SK_V;
    return SK_Y;
  endfunction

  // pixel whose luma sits in a Y slot
  function automatic logic [2:0] slot_pix(yuvp_mode_e m, logic [2:0] s);
    if (m == MODE_422) return (s < 3'd2) ? 3'd0 : 3'd1;
    case (s)
      3'd1:    return 3'd0;
      3'd2:    return 3'd1;
      3'd4:    return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/yuvp_slot_gen.sv
module yuvp_slot_gen
  import yuvp_pkg::*;
(
  input  yuvp_mode_e  mode,
  input  logic [1:0]  phase,
  input  logic        sol,
  input  logic        eol,
  input  logic [1:0]  ofs,
  input  logic [7:0]  y,
  input  logic [7:0]  u,
  input  logic [7:0]  v,
  input  logic [7:0]  v_hold,
  output logic [3:0]  push_cnt,
  output yuvp_ent_t   push_ent [PUSH_MAX]
);

  logic [7:0] y_c, u_c, v_c, v_use;
  assign y_c   = clamp8(y, Y_LO, Y_HI);
  assign u_c   = clamp8(u, C_LO, C_HI);
  assign v_c   = clamp8(v, C_LO, C_HI);
  assign v_use = (phase == 2'd0) ? v_c : v_hold;

  always_comb begin
    int nd, s, e, cnt, j;
    logic [2:0] slot;
    nd  = (sol && mode == MODE_422) ? int'(ofs) : 0;
    s   = int'(pix_first(mode, {1'b0, phase}));
    e   = eol ? int'(pix_first(mode, grp_pix(mode)))
              : int'(pix_first(mode, {1'b0, phase} + 3'd1));
    cnt = nd + e - s;
    for (int k = 0; k < PUSH_MAX; k++) begin
      push_ent[k] = '0;
      j    = k - nd;
      slot = 3'(s + j);
      if (k < nd) begin
        push_ent[k].en = 1'b0;
      end else if (j < e - s) begin
        push_ent[k].en = 1'b1;
        case (slot_kind(mode, slot))
          SK_U:    push_ent[k].b = u_c;
          SK_V:    push_ent[k].b = v_use;
          default: push_ent[k].b = (slot_pix(mode, slot) == {1'b0, phase}) ? y_c : Y_PAD;
        endcase
      end
      push_ent[k].last = eol && (k == cnt - 1);
    end
    push_cnt = 4'(cnt);
  end

endmodule

// File: rtl/yuvp_byte_fifo.sv
module yuvp_byte_fifo
  import yuvp_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            push_cnt,
  input  yuvp_ent_t             push_ent [PUSH_MAX],
  output logic                  room,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [8*LANES-1:0]    out_data,
  output logic [LANES-1:0]      out_be,
  output logic                  out_eol
);

  localparam int CW = $clog2(DEPTH + 1);

  yuvp_ent_t      ent_q [DEPTH];
  yuvp_ent_t      ent_n [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [LANES-1:0] take;
  logic [2:0]     n_take;
  logic           any_last;
  int             pop;

  assign fill = cnt_q;
  assign room = int'(cnt_q) <= DEPTH - PUSH_MAX;

  always_comb begin
    logic stop;
    stop     = 1'b0;
    any_last = 1'b0;
    n_take   = '0;
    for (int i = 0; i < LANES; i++) begin
      take[i] = (i < int'(cnt_q)) && !stop;
      if (take[i]) begin
        n_take = n_take + 3'd1;
        if (ent_q[i].last) begin
          stop     = 1'b1;
          any_last = 1'b1;
        end
      end
      out_data[8*i +: 8] = take[i] ? ent_q[i].b : 8'h00;
      out_be[i]          = take[i] && ent_q[i].en;
    end
    out_valid = (int'(n_take) == LANES) || any_last;
    out_eol   = any_last;
  end

  always_comb begin
    int base;
    pop  = (out_valid && out_ready) ? int'(n_take) : 0;
    base = int'(cnt_q) - pop;
    for (int i = 0; i < DEPTH; i++) begin
      ent_n[i] = (i + pop < int'(cnt_q)) ? ent_q[(i + pop) % DEPTH] : '0;
    end
    for (int k = 0; k < PUSH_MAX; k++) begin
      if (k < int'(push_cnt) && base + k < DEPTH) ent_n[base + k] = push_ent[k];
    end
    cnt_n = CW'(base + int'(push_cnt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
    end
  end

endmodule

// File: rtl/yuvp_packer.sv
module yuvp_packer
  import yuvp_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_mode,
  input  logic [1:0]  line_ofs,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sol,
  input  logic        in_eol,
  input  logic [7:0]  in_y,
  input  logic [7:0]  in_u,
  input  logic [7:0]  in_v,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [3:0]  out_be,
  output logic        out_eol
);

  localparam int CW = $clog2(DEPTH + 1);

  yuvp_mode_e mode;
  logic [1:0] phase_q, cur_phase;
  logic [2:0] phase_inc;
  logic [7:0] v_hold;
  logic       pix_fire;
  logic [3:0] gen_cnt, push_cnt;
  logic       fifo_room;
  logic [CW-1:0] fill_lvl;
  yuvp_ent_t  gen_ent [PUSH_MAX];

  assign mode      = yuvp_mode_e'(cfg_mode);
  assign cur_phase = in_sol ? 2'd0 : phase_q;
  assign phase_inc = {1'b0, cur_phase} + 3'd1;
  assign in_ready  = fifo_room;
  assign pix_fire  = in_valid && in_ready;
  assign push_cnt  = pix_fire ? gen_cnt : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      v_hold  <= C_LO;
    end else if (pix_fire) begin
      phase_q <= (in_eol || phase_inc == grp_pix(mode)) ? 2'd0 : phase_inc[1:0];
      if (cur_phase == 2'd0) v_hold <= clamp8(in_v, C_LO, C_HI);
    end
  end

  yuvp_slot_gen u_gen (
    .mode     (mode),
    .phase    (cur_phase),
    .sol      (in_sol),
    .eol      (in_eol),
    .ofs      (line_ofs),
    .y        (in_y),
    .u        (in_u),
    .v        (in_v),
    .v_hold   (v_hold),
    .push_cnt (gen_cnt),
    .push_ent (gen_ent)
  );

  yuvp_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (push_cnt),
    .push_ent  (gen_ent),
    .room      (fifo_room),
    .fill      (fill_lvl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_be    (out_be),
    .out_eol   (out_eol)
  );

endmodule

// File: rtl/yuvp_packer_chk.sv
module yuvp_packer_chk #(
  parameter int DEPTH = 12,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_mode,
  input logic [1:0]    phase_q,
  input logic [CW-1:0] fill_lvl,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic [3:0]    out_be,
  input logic          out_eol
);

  logic [3:0] lane_ok;
  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_ok[i] = !out_be[i] ||
                        (out_data[8*i +: 8] >= 8'd16 && out_data[8*i +: 8] <= 8'd240);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_be) && $stable(out_eol)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_lvl) <= DEPTH); // R10
  AST_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lane_ok == 4'hF); // R6
  AST_MIDLINE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eol |-> out_be[3]); // R9
  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_be != 4'h0); // R7
  AST_PAIR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> phase_q < 2'd2); // R1

endmodule

bind yuvp_packer yuvp_packer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .phase_q   (phase_q),
  .fill_lvl  (fill_lvl),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_be    (out_be),
  .out_eol   (out_eol)
);

// File: tb/yuvp_packer_tb.sv
module yuvp_packer_tb;

  typedef struct packed {
    logic       mode;
    logic [1:0] ofs;
    logic [6:0] npix;
    logic [7:0] seed;
    logic [1:0] bp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 7'd8,  8'd3,  2'd0},
    '{1'b0, 2'd1, 7'd9,  8'd5,  2'd1},
    '{1'b0, 2'd3, 7'd6,  8'd9,  2'd2},
    '{1'b1, 2'd0, 7'd16, 8'd11, 2'd0},
    '{1'b1, 2'd2, 7'd8,  8'd13, 2'd1},
    '{1'b1, 2'd0, 7'd11, 8'd17, 2'd2},
    '{1'b1, 2'd0, 7'd5,  8'd19, 2'd1},
    '{1'b0, 2'd2, 7'd1,  8'd23, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [1:0]  line_ofs = 2'd0;
  logic        in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [7:0]  in_y = 8'd0, in_u = 8'd0, in_v = 8'd0;
  logic        in_ready, out_valid, out_eol;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [3:0]  out_be;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] py [64], pu [64], pv [64];
  logic [31:0] q_data [$];
  logic [3:0]  q_be [$];
  logic        q_eol [$];

  always #10 clk = ~clk;

  yuvp_packer u_dut (.*);

  function automatic logic [7:0] ref_y(logic [7:0] x);
    return (x > 8'd235) ? 8'd235 : (x < 8'd16) ? 8'd16 : x;
  endfunction
  function automatic logic [7:0] ref_c(logic [7:0] x);
    return (x > 8'd240) ? 8'd240 : (x < 8'd16) ? 8'd16 : x;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model: lays out the line as a byte list, then cuts it into words
  task automatic build_expect(input logic mode, input logic [1:0] ofs, input int n);
    logic [7:0] bl [$];
    logic       el [$];
    logic [7:0] yy [4];
    int g;
    g = mode ? 4 : 2;
    if (!mode) for (int k = 0; k < ofs; k++) begin bl.push_back(8'h00); el.push_back(1'b0); end
    for (int s = 0; s < n; s += g) begin
      for (int k = 0; k < 4; k++) yy[k] = (s + k < n) ? ref_y(py[s + k]) : 8'd16;
      if (!mode) begin
        bl.push_back(ref_c(pu[s])); bl.push_back(yy[0]);
        bl.push_back(ref_c(pv[s])); bl.push_back(yy[1]);
        repeat (4) el.push_back(1'b1);
      end else begin
        bl.push_back(ref_c(pu[s])); bl.push_back(yy[0]); bl.push_back(yy[1]);
        bl.push_back(ref_c(pv[s])); bl.push_back(yy[2]); bl.push_back(yy[3]);
        repeat (6) el.push_back(1'b1);
      end
    end
    for (int w = 0; w < bl.size(); w += 4) begin
      logic [31:0] d;
      logic [3:0]  b;
      d = '0; b = '0;
      for (int l = 0; l < 4; l++) if (w + l < bl.size()) begin
        d[8*l +: 8] = bl[w + l];
        b[l] = el[w + l];
      end
      q_data.push_back(d); q_be.push_back(b); q_eol.push_back(w + 4 >= bl.size());
    end
  endtask

  task automatic run_line(input logic mode, input logic [1:0] ofs, input int n, input int bp, input string tag);
    int idx, guard;
    logic stalled;
    logic [36:0] held;
    idx = 0; guard = 0; stalled = 1'b0; held = '0;
    build_expect(mode, ofs, n);
    while ((idx < n || q_data.size() > 0) && guard < 2000) begin
      @(negedge clk);
      guard++; cyc++;
      cfg_mode = mode; line_ofs = ofs;
      in_valid = idx < n;
      in_sol   = idx == 0;
      in_eol   = idx == n - 1;
      in_y = (idx < n) ? py[idx] : 8'd0;
      in_u = (idx < n) ? pu[idx] : 8'd0;
      in_v = (idx < n) ? pv[idx] : 8'd0;
      out_ready = (bp == 0) ? 1'b1 : (bp == 1) ? cyc[0] : (cyc % 4 == 3);
      #2;
      if (stalled) // R10
        check(out_valid && {out_eol, out_be, out_data} == held, "R10 hold",
              {27'd0, out_eol, out_be, out_data}, {27'd0, held});
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) check(1'b0, {tag, " extra word"}, {32'd0, out_data}, 64'd0);
        else begin
          logic [31:0] ed; logic [3:0] eb; logic ee;
          ed = q_data.pop_front(); eb = q_be.pop_front(); ee = q_eol.pop_front();
          check({out_eol, out_be, out_data} == {ee, eb, ed}, tag,
                {27'd0, out_eol, out_be, out_data}, {27'd0, ee, eb, ed});
        end
      end
      stalled = out_valid && !out_ready;
      held    = {out_eol, out_be, out_data};
      if (in_valid && in_ready) idx++;
    end
    check(guard < 2000, {tag, " line completes"}, 64'(guard), 64'd2000);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #2 check(!out_valid, {tag, " no trailing word"}, {63'd0, out_valid}, 64'd0);
    q_data.delete(); q_be.delete(); q_eol.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 check(!out_valid && in_ready, "R11 reset state", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;

    // table walk: layouts, offsets, partial groups, back-pressure
    for (int t = 0; t < NV; t++) begin
      for (int i = 0; i < 64; i++) begin
        py[i] = 8'((int'(VECS[t].seed) * 37 + i * 53) & 255);
        pu[i] = 8'((int'(VECS[t].seed) * 11 + i * 97) & 255);
        pv[i] = 8'((int'(VECS[t].seed) * 71 + i * 29) & 255);
      end
      run_line(VECS[t].mode, VECS[t].ofs, int'(VECS[t].npix), int'(VECS[t].bp),
               VECS[t].mode ? (VECS[t].ofs != 0 ? "R8 offset ignored" :
                               (VECS[t].npix % 4 != 0) ? "R9 411 pad" : "R3 411 order")
                            : (VECS[t].ofs != 0 ? "R7 start lane" : "R1 422 order"));
    end

    // luma clamp: 0 -> 16, 255 -> 235
    py[0] = 8'd0;  py[1] = 8'd255; pu[0] = 8'd128; pv[0] = 8'd128; pu[1] = 8'd1; pv[1] = 8'd2;
    run_line(1'b0, 2'd0, 2, 0, "R5 luma clamp");
    // chroma clamp: 3 -> 16, 250 -> 240
    py[0] = 8'd100; py[1] = 8'd100; pu[0] = 8'd3; pv[0] = 8'd250;
    run_line(1'b0, 2'd0, 2, 0, "R6 chroma clamp");
    // second pixel chroma must not show
    pu[0] = 8'd40; pv[0] = 8'd200; pu[1] = 8'd90; pv[1] = 8'd90;
    run_line(1'b0, 2'd0, 2, 1, "R2 pair chroma");
    // 4:1:1 group chroma from pixel 0 only
    for (int i = 0; i < 4; i++) begin py[i] = 8'(50 + i); pu[i] = 8'(60 + 40*i); pv[i] = 8'(70 + 30*i); end
    run_line(1'b1, 2'd0, 4, 0, "R4 group chroma");
    // 4:2:2 odd-length line with offset: pad and flush
    for (int i = 0; i < 8; i++) begin py[i] = 8'(20 + 9*i); pu[i] = 8'(30 + i); pv[i] = 8'(180 - i); end
    run_line(1'b0, 2'd3, 3, 2, "R9 422 pad");
    run_line(1'b0, 2'd1, 5, 1, "R7 offset pad");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule